// File: doc/BRIEF.md
# Regulator power sequencing supervisor

This block is the digital sequencer and fault supervisor for a step-down converter. It walks the converter from idle through soft start and output qualification to normal operation, and back down again on disable. It grants separate permissions to the high-side and low-side gate drivers, tells the modulator whether pulse skipping is allowed, requests the soft-start ramp and presents a reference code to an external DAC. The analog comparators, the ramp generator, the modulator and the DAC are all outside the block; only their digital flags and codes pass through it.

A power-good output is released only after the output has stayed above 90% of target for a fixed number of timebase ticks. It is then qualified continuously against a regulation window, an auxiliary-rail-low flag and a set of reference-ready flags. An overvoltage or undervoltage event latches a fault that only a disable can clear, unless a strap input turns protection off. The all-ones voltage code means no processor is fitted and is treated like a disable.

Top module: `pwr_seq_sup`

## Requirements
- R1: A voltage code of 1111 counts as a disable. Power-good and the auxiliary-rail enable drop one cycle later and the shutdown sequence runs. No start is made while the code stays 1111, and the reference code keeps its last value.
- R2: One cycle after each clock edge where the voltage code is not 1111, the reference code is {range, 14 - code}. For the low range the target is 1300 mV + 50 mV per step, and for the high range it is 2100 mV + 100 mV per step. A code change while running updates it without restarting soft start and without dropping power-good.
- R3: Raising enable gives soft-start request, high-side and low-side permission one cycle later. After soft-start-done, the block waits for the 90% flag. Power-good rises on the 16th tick counted while that flag stays set. A drop of the flag restarts the count.
- R4: While running, power-good equals in-window AND NOT auxiliary-low AND all reference-ready flags set.
- R5: With protection on, an overvoltage flag forces the high side off and the low side on, and drops power-good. This happens directly, with no tick delay, and holds after the flag clears until enable goes low. A later enable restarts normally.
- R6: With protection on, an undervoltage flag while running latches a fault with both drivers off until enable goes low.
- R7: With the protection strap high, the overvoltage and undervoltage flags have no effect.
- R8: When idle, the low side is held on and the high side off if protection is on. If the strap is high, both are held off.
- R9: On disable, power-good falls at once and both drivers are held off for 16 ticks. After that the idle driver state of R8 applies.
- R10: The skip-allowed output is high only while qualifying or running, and only when the continuous-mode input is low. It follows that input with one cycle of latency.
- R11: Comparator flags pass through two synchronizer stages. Their effect shows on the outputs three clock edges after the change. Enable, code, strap and tick act on the next edge.
- R12: Under synchronous reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable request |
| vid_i | input | VIDW | Voltage identification code (all ones = no processor) |
| range_i | input | 1 | Reference range select (1 = high range) |
| prot_off_i | input | 1 | Strap: 1 disables overvoltage/undervoltage protection |
| cont_mode_i | input | 1 | 1 forces continuous conduction (no skipping) |
| tick_i | input | 1 | Single-cycle timebase tick |
| ss_done_i | input | 1 | Soft-start ramp finished flag |
| out_ok90_i | input | 1 | Output at or above 90% of target |
| out_inwin_i | input | 1 | Output inside the ±10% window |
| aux_low_i | input | 1 | Auxiliary rail below its threshold |
| ref_ready_i | input | NREF | Internal reference ready flags |
| ov_i | input | 1 | Overvoltage flag |
| uv_i | input | 1 | Undervoltage flag |
| hs_en_o | output | 1 | High-side driver permission |
| ls_en_o | output | 1 | Low-side driver permission |
| skip_en_o | output | 1 | Pulse skipping allowed |
| ss_req_o | output | 1 | Soft-start request |
| aux_en_o | output | 1 | Auxiliary rail enable |
| ref_code_o | output | VIDW+1 | Reference code {range, step} |
| pgood_o | output | 1 | Power-good (1 = released) |

## Verification
The checker watches several properties on every cycle. It checks that the reference code tracks the voltage code one cycle later, that a 1111 code always drops power-good and the auxiliary enable, and that power-good only rises from the qualifying or running phase. It also checks that a latched fault stays latched while enable is high, that the disable delay keeps both drivers off, and that skipping never follows a set continuous-mode input. Other behaviours can only be shown by the bench scenarios. These are the exact 16-tick counts and their restart on a flag drop, the three-edge flag latency, the driver state left behind by each fault kind, the strap masking faults, and power-good tracking random window, rail and reference flags.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SOFT   = 3'd1,
    ST_WAITPG = 3'd2,
    ST_RUN    = 3'd3,
    ST_SDLY   = 3'd4,
    ST_FAULT  = 3'd5
  } pss_state_e;

  typedef enum logic {
    FK_OV = 1'b0,
    FK_UV = 1'b1
  } pss_fault_e;

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/pss_tick_timer.sv
module pss_tick_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pss_ref_map.sv
module pss_ref_map #(
  parameter int VIDW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VIDW-1:0] vid_i,
  input  logic            range_i,
  input  logic            hold_i,
  output logic [VIDW:0]   code_o
);

  logic [VIDW-1:0] step;

  // Codes count downward: the step index is the inverted code minus one.
  assign step = (~vid_i) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
    end else if (!hold_i) begin
      code_o <= {range_i, step};
    end
  end

endmodule

// File: rtl/pwr_seq_sup.sv
module pwr_seq_sup
  import pss_pkg::*;
#(
  parameter int NREF  = 3,
  parameter int TICKS = 16,
  parameter int VIDW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic [VIDW-1:0] vid_i,
  input  logic            range_i,
  input  logic            prot_off_i,
  input  logic            cont_mode_i,
  input  logic            tick_i,
  input  logic            ss_done_i,
  input  logic            out_ok90_i,
  input  logic            out_inwin_i,
  input  logic            aux_low_i,
  input  logic [NREF-1:0] ref_ready_i,
  input  logic            ov_i,
  input  logic            uv_i,
  output logic            hs_en_o,
  output logic            ls_en_o,
  output logic            skip_en_o,
  output logic            ss_req_o,
  output logic            aux_en_o,
  output logic [VIDW:0]   ref_code_o,
  output logic            pgood_o
);

  localparam int FW = NREF + 6;

  logic [FW-1:0] raw_f, syn_f;
  logic ov_s, uv_s, ok90_s, inwin_s, auxlow_s, ssdone_s;
  logic [NREF-1:0] refrdy_s;

  assign raw_f = {ov_i, uv_i, out_ok90_i, out_inwin_i, aux_low_i, ss_done_i, ref_ready_i};

  pss_sync #(.W(FW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_f),
    .q_o (syn_f)
  );

  assign ov_s     = syn_f[FW-1];
  assign uv_s     = syn_f[FW-2];
  assign ok90_s   = syn_f[FW-3];
  assign inwin_s  = syn_f[FW-4];
  assign auxlow_s = syn_f[FW-5];
  assign ssdone_s = syn_f[FW-6];
  assign refrdy_s = syn_f[NREF-1:0];

  logic nocpu, run_req, prot_on, pg_ok;
  assign nocpu   = &vid_i;
  assign run_req = en_i && !nocpu;
  assign prot_on = !prot_off_i;
  assign pg_ok   = inwin_s && !auxlow_s && (&refrdy_s);

  pss_state_e state_q, state_n;
  pss_fault_e fk_q, fk_n;
  logic tmr_tick, tmr_clr, tmr_done;

  assign tmr_tick = tick_i && ((state_q == ST_SDLY) || (state_q == ST_WAITPG && ok90_s));
  assign tmr_clr  = (state_n != state_q) || (state_q == ST_WAITPG && !ok90_s);

  pss_tick_timer #(.TICKS(TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (tmr_clr),
    .tick_i (tmr_tick),
    .done_o (tmr_done)
  );

  pss_ref_map #(.VIDW(VIDW)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .vid_i   (vid_i),
    .range_i (range_i),
    .hold_i  (nocpu),
    .code_o  (ref_code_o)
  );

  always_comb begin
    state_n = state_q;
    fk_n    = fk_q;
    unique case (state_q)
      ST_OFF: begin
        if (run_req) state_n = ST_SOFT;
      end
      ST_SOFT, ST_WAITPG, ST_RUN: begin
        if (prot_on && ov_s) begin
          state_n = ST_FAULT;
          fk_n    = FK_OV;
        end else if (!run_req) begin
          state_n = ST_SDLY;
        end else if (state_q == ST_RUN && prot_on && uv_s) begin
          state_n = ST_FAULT;
          fk_n    = FK_UV;
        end else if (state_q == ST_SOFT && ssdone_s) begin
          state_n = ST_WAITPG;
        end else if (state_q == ST_WAITPG && tmr_done) begin
          state_n = ST_RUN;
        end
      end
      ST_SDLY: begin
        if (prot_on && ov_s) begin
          state_n = ST_FAULT;
          fk_n    = FK_OV;
        end else if (tmr_done) begin
          state_n = ST_OFF;
        end
      end
      ST_FAULT: begin
        if (!en_i) state_n = ST_OFF;
      end
      default: state_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      fk_q      <= FK_OV;
      hs_en_o   <= 1'b0;
      ls_en_o   <= 1'b0;
      skip_en_o <= 1'b0;
      ss_req_o  <= 1'b0;
      aux_en_o  <= 1'b0;
      pgood_o   <= 1'b0;
    end else begin
      state_q   <= state_n;
      fk_q      <= fk_n;
      aux_en_o  <= run_req;
      hs_en_o   <= state_n inside {ST_SOFT, ST_WAITPG, ST_RUN};
      ss_req_o  <= (state_n == ST_SOFT);
      skip_en_o <= (state_n inside {ST_WAITPG, ST_RUN}) && !cont_mode_i;
      pgood_o   <= (state_n == ST_RUN) && pg_ok;
      unique case (state_n)
        ST_OFF:                      ls_en_o <= prot_on;
        ST_SOFT, ST_WAITPG, ST_RUN:  ls_en_o <= 1'b1;
        ST_FAULT:                    ls_en_o <= (fk_n == FK_OV);
        default:                     ls_en_o <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pss_chk.sv
module pss_chk
  import pss_pkg::*;
#(
  parameter int VIDW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            en_i,
  input logic [VIDW-1:0] vid_i,
  input logic            range_i,
  input logic            prot_off_i,
  input logic            cont_mode_i,
  input logic            hs_en_o,
  input logic            ls_en_o,
  input logic            skip_en_o,
  input logic            aux_en_o,
  input logic            pgood_o,
  input logic [VIDW:0]   ref_code_o,
  input pss_state_e      state_q
);

  localparam logic [VIDW-1:0] TOPSTEP = {{(VIDW-1){1'b1}}, 1'b0};

  a_r1_nocpu_drops: assert property (@(posedge clk) disable iff (rst)
    (&vid_i) |=> (!pgood_o && !aux_en_o));

  a_r2_ref_tracks: assert property (@(posedge clk) disable iff (rst)
    !(&vid_i) |=> (ref_code_o == {$past(range_i), TOPSTEP - $past(vid_i)}));

  a_r3_pg_source: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood_o) |-> ($past(state_q) == ST_WAITPG || $past(state_q) == ST_RUN));

  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FAULT && en_i) |=> (state_q == ST_FAULT));

  a_r9_delay_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SDLY) |-> (!hs_en_o && !ls_en_o && !pgood_o));

  a_r8_idle_drive: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && state_q == ST_OFF && $past(state_q) == ST_OFF && $stable(prot_off_i))
      |-> (!hs_en_o && (ls_en_o == !prot_off_i)));

  a_r10_skip_mode: assert property (@(posedge clk) disable iff (rst)
    skip_en_o |-> !$past(cont_mode_i));

endmodule

bind pwr_seq_sup pss_chk #(.VIDW(VIDW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .vid_i       (vid_i),
  .range_i     (range_i),
  .prot_off_i  (prot_off_i),
  .cont_mode_i (cont_mode_i),
  .hs_en_o     (hs_en_o),
  .ls_en_o     (ls_en_o),
  .skip_en_o   (skip_en_o),
  .aux_en_o    (aux_en_o),
  .pgood_o     (pgood_o),
  .ref_code_o  (ref_code_o),
  .state_q     (state_q)
);

// File: tb/pwr_seq_sup_test.sv
`timescale 1ns/1ps
module pwr_seq_sup_test;

  localparam int NREF = 3;
  localparam int VIDW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, range_s = 0, prot_off = 0, cont = 0, tick = 0;
  logic ss_done = 0, ok90 = 0, inwin = 1, aux_low = 0, ov = 0, uv = 0;
  logic [VIDW-1:0] vid = 4'd8;
  logic [NREF-1:0] ref_rdy = '1;
  logic hs, ls, skip, ss_req, aux_en, pgood;
  logic [VIDW:0] ref_code;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  pwr_seq_sup #(.NREF(NREF), .TICKS(16), .VIDW(VIDW)) uut (
    .clk(clk), .rst(rst), .en_i(en), .vid_i(vid), .range_i(range_s),
    .prot_off_i(prot_off), .cont_mode_i(cont), .tick_i(tick),
    .ss_done_i(ss_done), .out_ok90_i(ok90), .out_inwin_i(inwin),
    .aux_low_i(aux_low), .ref_ready_i(ref_rdy), .ov_i(ov), .uv_i(uv),
    .hs_en_o(hs), .ls_en_o(ls), .skip_en_o(skip), .ss_req_o(ss_req),
    .aux_en_o(aux_en), .ref_code_o(ref_code), .pgood_o(pgood)
  );

  function automatic logic [VIDW:0] exp_ref(logic r, logic [VIDW-1:0] v);
    int s = 14 - int'(v);
    return {r, 4'(s)};
  endfunction

  function automatic logic exp_pg(logic w, logic a, logic [NREF-1:0] rr);
    return w && !a && (rr == {NREF{1'b1}});
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1; step(1);
      tick = 0; step(1);
    end
  endtask

  task automatic bring_up(string req);
    en = 1; step(3);
    ticks(16);
    chk(req, "pgood after bring-up", pgood, 1);
    chk(req, "hs after bring-up", hs, 1);
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h1d5e);
    step(3);
    // R12: reset state
    chk("R12", "hs in reset", hs, 0);
    chk("R12", "ls in reset", ls, 0);
    chk("R12", "pgood in reset", pgood, 0);
    chk("R12", "ref in reset", ref_code, 0);
    rst = 0;
    step(2);
    // R8: idle with protection on
    chk("R8", "idle ls", ls, 1);
    chk("R8", "idle hs", hs, 0);
    chk("R2", "ref after reset", ref_code, exp_ref(0, 4'd8));

    // R3: startup
    en = 1; step(1);
    chk("R3", "ss_req", ss_req, 1);
    chk("R3", "hs", hs, 1);
    chk("R3", "ls", ls, 1);
    chk("R1", "aux_en enabled", aux_en, 1);
    ss_done = 1; ok90 = 1;
    step(2);
    chk("R11", "ss_req before sync", ss_req, 1);
    step(1);
    chk("R11", "ss_req after sync", ss_req, 0);
    chk("R10", "skip while qualifying", skip, 1);
    ticks(10);
    ok90 = 0; step(3);
    ok90 = 1; step(3);
    ticks(15);
    chk("R3", "pgood after 15 ticks", pgood, 0);
    tick = 1; step(1); tick = 0;
    chk("R3", "pgood on 16th tick", pgood, 1);
    step(1);

    // R10: continuous mode
    cont = 1; step(1);
    chk("R10", "skip with cont", skip, 0);
    cont = 0; step(1);
    chk("R10", "skip without cont", skip, 1);

    // R4: random pgood qualification
    for (int i = 0; i < 24; i++) begin
      inwin   = 1'($urandom_range(0, 1));
      aux_low = 1'($urandom_range(0, 1));
      ref_rdy = NREF'($urandom_range(0, (1 << NREF) - 1));
      if (i % 4 == 0) begin inwin = 1; aux_low = 0; ref_rdy = '1; end
      step(3);
      chk("R4", "pgood qualification", pgood, exp_pg(inwin, aux_low, ref_rdy));
    end
    inwin = 1; aux_low = 0; ref_rdy = '1; step(3);
    chk("R4", "pgood restored", pgood, 1);

    // R2: random code changes while running
    for (int i = 0; i < 24; i++) begin
      vid     = 4'($urandom_range(0, 14));
      range_s = 1'($urandom_range(0, 1));
      if (i == 0) vid = 4'd14;
      if (i == 1) vid = 4'd0;
      step(1);
      chk("R2", "ref code", ref_code, exp_ref(range_s, vid));
      chk("R2", "no restart", ss_req, 0);
      chk("R2", "pgood kept", pgood, 1);
    end
    vid = 4'd8; range_s = 0; step(1);

    // R7: strap masks faults
    prot_off = 1; ov = 1; uv = 1; step(5);
    chk("R7", "pgood with masked faults", pgood, 1);
    chk("R7", "hs with masked faults", hs, 1);
    ov = 0; uv = 0; step(3);
    prot_off = 0; step(1);
    chk("R7", "still running", pgood, 1);

    // R6: undervoltage latch
    uv = 1; step(3);
    chk("R6", "hs after uv", hs, 0);
    chk("R6", "ls after uv", ls, 0);
    chk("R6", "pgood after uv", pgood, 0);
    uv = 0; step(4);
    chk("R6", "uv latched ls", ls, 0);
    chk("R6", "uv latched hs", hs, 0);
    en = 0; step(1);
    chk("R8", "idle ls after fault", ls, 1);

    // R5: overvoltage latch
    bring_up("R5");
    ov = 1; step(2);
    chk("R11", "hs before ov sync", hs, 1);
    step(1);
    chk("R5", "hs after ov", hs, 0);
    chk("R5", "ls after ov", ls, 1);
    chk("R5", "pgood after ov", pgood, 0);
    ov = 0; step(4);
    chk("R5", "ov latched hs", hs, 0);
    chk("R5", "ov latched ls", ls, 1);
    en = 0; step(1);
    bring_up("R5");

    // R9: disable delay
    en = 0; step(1);
    chk("R9", "pgood falls", pgood, 0);
    chk("R9", "ls off in delay", ls, 0);
    chk("R9", "hs off in delay", hs, 0);
    ticks(15);
    chk("R9", "ls after 15 ticks", ls, 0);
    tick = 1; step(1); tick = 0;
    chk("R9", "ls after 16 ticks", ls, 1);
    step(1);

    // R8: strap in idle
    prot_off = 1; step(1);
    chk("R8", "strap idle ls", ls, 0);
    prot_off = 0; step(1);
    chk("R8", "protected idle ls", ls, 1);

    // R1: no-processor code
    bring_up("R1");
    vid = 4'hF; step(1);
    chk("R1", "pgood on nocpu", pgood, 0);
    chk("R1", "aux_en on nocpu", aux_en, 0);
    chk("R1", "hs on nocpu", hs, 0);
    ticks(16);
    chk("R1", "ls after delay", ls, 1);
    step(4);
    chk("R1", "no start", ss_req, 0);
    chk("R1", "ref held", ref_code, exp_ref(0, 4'd8));
    vid = 4'd8; step(1);
    chk("R1", "start after valid code", ss_req, 1);
    en = 0; step(1);
    ticks(16);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule